// File: doc/BRIEF.md
# In-Place Adjacent-Swap Byte Sorter

This block sorts a run of bytes that sit in a single-port RAM starting at address 0. The sort happens in place. A one-cycle start pulse captures the element count and a direction bit, which selects ascending or descending order. The block then makes a fixed number of passes over the array. In each pass it reads an element and the element after it, and compares the two as unsigned values. When the pair is out of order, it writes the pair back exchanged.

The number of passes is fixed. There are count-1 passes, and each pass makes count-1 comparisons. The block never stops early, even when the array is already in order. Two equal values always count as ordered, whichever direction is selected. When the final comparison is finished, a single-cycle done pulse is raised.

The memory port is a plain strobe interface with no back-pressure. A read strobe returns data on `mem_rdata` one cycle later, and a write strobe stores `mem_wdata` at the clock edge. There is no valid/ready handshake, because the RAM always accepts an access. The block never issues a read and a write in the same cycle.

Top module: `bytesort_core`

## Requirements
- R1: While reset is held and after it is released, with no start, `done`, `mem_rd` and `mem_wr` are all low.
- R2: A start with count N >= 2 performs exactly N-1 passes. Each pass compares N-1 adjacent pairs, taking addresses 0/1, then 1/2, and so on up to N-2/N-1. When done pulses, addresses 0..N-1 hold the result of that procedure.
- R3: When `descend` = 0 (ascending), a pair is exchanged only when the lower-address byte is strictly greater than the higher-address byte, compared unsigned.
- R4: When `descend` = 1 (descending), a pair is exchanged only when the lower-address byte is strictly less than the higher-address byte, compared unsigned.
- R5: A pair of equal bytes is never exchanged and causes no memory write.
- R6: An exchange is two writes on consecutive cycles. The first writes the higher-address byte to the lower address. The second writes the saved lower-address byte to the higher address.
- R7: A comparison with no exchange takes 3 cycles, and one with an exchange takes 5. `done` is high for exactly one cycle: the cycle after the last comparison, or after its last write. Read data is expected one cycle after `mem_rd`.
- R8: A start with N = 0 or N = 1 raises `done` in the cycle after start and makes no memory access.
- R9: A start pulse while a sort is in progress is ignored. The running sort keeps its count, its direction and its timing.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sort, honoured only when idle |
| descend | input | 1 | Sort direction: 0 ascending, 1 descending; captured with start |
| count | input | AW+1 | Number of elements N, captured with start |
| done | output | 1 | One-cycle pulse when sorting ends |
| mem_rd | output | 1 | Read strobe; data is returned on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Memory address for the read or write |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data from the RAM |

## Verification
The assertions take three things for granted. The RAM returns read data exactly one cycle after a read strobe. `count` never exceeds the RAM depth. Start is presented only as a single-cycle pulse. The bench RAM model has that one-cycle latency, and every count it issues lies between 0 and 16. Start is held high for exactly one cycle at a falling edge. This is also true of the pulse injected mid-sort, which checks that a busy sorter ignores start.

// File: rtl/bytesort_pkg.sv
package bytesort_pkg;
  typedef enum logic [2:0] {
    SS_IDLE,
    SS_RD_LO,
    SS_RD_HI,
    SS_CMP,
    SS_WR_LO,
    SS_WR_HI,
    SS_FIN
  } sort_state_e;
endpackage

// File: rtl/bytesort_order.sv
module bytesort_order #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] lo_val,
  input  logic [DW-1:0] hi_val,
  input  logic          descend,
  output logic          exchange
);
  // Unsigned compare; equality never exchanges.
  always_comb begin
    if (descend) exchange = (lo_val < hi_val);
    else         exchange = (lo_val > hi_val);
  end
endmodule

// File: rtl/bytesort_loops.sv
module bytesort_loops #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] span,
  input  logic          advance,
  output logic          pass_end,
  output logic          sort_end
);
  logic [CW-1:0] inner_q, outer_q, span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
      span_q  <= '0;
    end else if (load) begin
      inner_q <= span;
      outer_q <= span;
      span_q  <= span;
    end else if (advance) begin
      if (inner_q == CW'(1)) begin
        inner_q <= span_q;
        outer_q <= outer_q - CW'(1);
      end else begin
        inner_q <= inner_q - CW'(1);
      end
    end
  end

  assign pass_end = (inner_q == CW'(1));
  assign sort_end = pass_end && (outer_q == CW'(1));

  // R2
  ctr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (inner_q != '0) && (outer_q != '0) && (inner_q <= span_q));
endmodule

// File: rtl/bytesort_core.sv
module bytesort_core #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          descend,
  input  logic [AW:0]   count,
  output logic          done,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import bytesort_pkg::*;
  localparam int CW = AW + 1;

  sort_state_e   state_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] lo_q, hi_q;
  logic          desc_q;
  logic          exchange, advance, pass_end, sort_end, load, multi;

  assign multi   = (count > CW'(1));
  assign load    = (state_q == SS_IDLE) && start && multi;
  assign advance = ((state_q == SS_CMP) && !exchange) || (state_q == SS_WR_HI);

  bytesort_order #(.DW(DW)) u_order (
    .lo_val   (lo_q),
    .hi_val   (mem_rdata),
    .descend  (desc_q),
    .exchange (exchange)
  );

  bytesort_loops #(.CW(CW)) u_loops (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .span     (count - CW'(1)),
    .advance  (advance),
    .pass_end (pass_end),
    .sort_end (sort_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      ptr_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      desc_q  <= 1'b0;
    end else begin
      case (state_q)
        SS_IDLE: if (start) begin
          desc_q  <= descend;
          ptr_q   <= '0;
          state_q <= multi ? SS_RD_LO : SS_FIN;
        end
        SS_RD_LO: state_q <= SS_RD_HI;
        SS_RD_HI: begin
          lo_q    <= mem_rdata;
          state_q <= SS_CMP;
        end
        SS_CMP: begin
          hi_q <= mem_rdata;
          if (exchange) state_q <= SS_WR_LO;
        end
        SS_WR_LO: state_q <= SS_WR_HI;
        default:  state_q <= SS_IDLE;
      endcase
      if (advance) begin
        ptr_q   <= pass_end ? '0 : ptr_q + AW'(1);
        state_q <= sort_end ? SS_FIN : SS_RD_LO;
      end
    end
  end

  assign mem_rd    = (state_q == SS_RD_LO) || (state_q == SS_RD_HI);
  assign mem_wr    = (state_q == SS_WR_LO) || (state_q == SS_WR_HI);
  assign mem_addr  = ((state_q == SS_RD_HI) || (state_q == SS_WR_HI)) ? ptr_q + AW'(1) : ptr_q;
  assign mem_wdata = (state_q == SS_WR_LO) ? hi_q : lo_q;
  assign done      = (state_q == SS_FIN);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_WR_LO) |=> mem_wr && (mem_addr == AW'($past(mem_addr) + AW'(1))));
  // R3
  asc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_WR_HI && !desc_q) |-> ($past(mem_wdata) < mem_wdata));
  // R4
  desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_WR_HI && desc_q) |-> ($past(mem_wdata) > mem_wdata));
  // R8
  small_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_IDLE && start && !multi) |=> done && !mem_rd && !mem_wr);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SS_IDLE && start) |=> $stable(desc_q) && (state_q != SS_IDLE || $past(done)));
endmodule

// File: tb/bytesort_core_test.sv
module bytesort_core_test;
  localparam int DW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          descend = 1'b0;
  logic [AW:0]   count = '0;
  logic          done, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] ram [0:255];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bytesort_core #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .descend(descend), .count(count),
    .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_sort(input int n, input bit dsc, input bit poke);
    logic [DW-1:0] model [0:255];
    int wa[$];
    int wd[$];
    int t = 0;
    for (int i = 0; i < 256; i++) model[i] = ram[i];
    for (int p = 0; p < n - 1; p++) begin
      for (int i = 0; i < n - 1; i++) begin
        logic [DW-1:0] x, y;
        bit sw;
        x = model[i];
        y = model[i+1];
        sw = dsc ? (x < y) : (x > y);
        t += 3;
        if (sw) begin
          wa.push_back(i);     wd.push_back(int'(y));
          wa.push_back(i + 1); wd.push_back(int'(x));
          model[i] = y;
          model[i+1] = x;
          t += 2;
        end
      end
    end
    @(negedge clk);
    start = 1'b1; count = (AW+1)'(n); descend = dsc;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= t + 2; j++) begin
      if (j > 0) @(negedge clk);
      if (poke && j == 4) begin
        start = 1'b1; count = (AW+1)'(1); descend = ~dsc;
      end else begin
        start = 1'b0;
      end
      chk(done == (j == t), "R7 done timing", int'(done), int'(j == t));
      chk(!(mem_rd && mem_wr), "R10 rd/wr overlap", 1, 0);
      if (n < 2) chk(!mem_rd && !mem_wr, "R8 access on small count", int'(mem_rd | mem_wr), 0);
      if (mem_wr) begin
        if (wa.size() == 0) begin
          chk(1'b0, "R5 unexpected write", int'(mem_addr), -1);
        end else begin
          int ea, ed;
          ea = wa.pop_front();
          ed = wd.pop_front();
          chk(int'(mem_addr) == ea, "R6 write address", int'(mem_addr), ea);
          chk(int'(mem_wdata) == ed, dsc ? "R4 write data" : "R3 write data", int'(mem_wdata), ed);
        end
      end
    end
    chk(wa.size() == 0, "R6 missing writes", wa.size(), 0);
    for (int i = 0; i < 256; i++)
      if (ram[i] !== model[i]) chk(1'b0, poke ? "R9 array after busy start" : "R2 array", int'(ram[i]), int'(model[i]));
    chk(1'b1, "R2 array compared", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = DW'((i * 73 + 29) % 256);
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R1 during reset", int'({done, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R1 after reset", int'({done, mem_rd, mem_wr}), 0);

    // R2 R3: ascending on scattered data
    run_sort(10, 1'b0, 1'b0);
    // R4: descending on the now ascending data
    run_sort(10, 1'b1, 1'b0);
    // R5: duplicates in both directions
    for (int i = 0; i < 12; i++) ram[i] = DW'((i % 3) * 40);
    run_sort(12, 1'b0, 1'b0);
    run_sort(12, 1'b1, 1'b0);
    // R5: all equal, no writes at all
    for (int i = 0; i < 6; i++) ram[i] = 8'h5A;
    run_sort(6, 1'b0, 1'b0);
    // R3: unsigned extremes
    ram[0] = 8'hFF; ram[1] = 8'h00; ram[2] = 8'h80; ram[3] = 8'h7F;
    run_sort(4, 1'b0, 1'b0);
    // R8: zero and one element
    run_sort(0, 1'b0, 1'b0);
    run_sort(1, 1'b1, 1'b0);
    // R2: two elements, both directions
    run_sort(2, 1'b1, 1'b0);
    run_sort(2, 1'b0, 1'b0);
    // R9: start pulse while busy
    for (int i = 0; i < 16; i++) ram[i] = DW'((i * 151 + 7) % 256);
    run_sort(16, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk(!done && !mem_rd && !mem_wr, "R9 idle after busy start", int'({done, mem_rd, mem_wr}), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule